// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Sequencer

This block is the bus master's state sequencer. It runs read and write cycles on an external bus with one clock per bus state. Each cycle is either non-pipelined or pipelined, and the system chooses between them cycle by cycle. A cycle starts by putting an address and cycle definition on the bus together with an address strobe. The system ends the cycle by asserting an active-low ready. Until ready arrives, the sequencer adds wait states, with no upper limit.

The system can assert an active-low next-address input while a cycle is still in progress. The sequencer then puts the following cycle's address on the bus before the current cycle is acknowledged. This keeps the bus one cycle ahead. An active-low half-width indication, sampled at acknowledge, can make the sequencer run a second cycle that carries only the upper half of the byte lanes. A hold request parks the bus in a hold state, but only between cycles.

The internal requester presents one request (address, byte enables, direction) and holds it until the sequencer accepts it with `req_take`.

Top module: `pipe_bus_seq`

## Requirements
- R1: Synchronous active-low reset puts the sequencer in idle. In idle, `bus_state` reads 0, `ads_n` is high, `data_oe` is low and `hold_ack` is low. The state codes are: idle 0, hold 1, T1 2, T2 3, T2I 4, T2P 5, T1P 6.
- R2: From idle or hold, a pending request starts a cycle in T1. T1 asserts `ads_n` low with the new address. T1 always moves to T2, whatever ready and next-address do.
- R3: Ready is sampled only at the end of T2, T2I and T2P. If ready is high, the cycle stays in its wait state for as many clocks as ready stays high.
- R4: When a cycle is acknowledged in T2 or T2I, the next state is hold if `hold_req` is high. Otherwise it is T1 if a request is pending, and otherwise idle.
- R5: Next-address is ignored in T1. It is sampled in T2 and T1P only while `half_n` is high. If it is sampled low and the cycle is not acknowledged, the next state is T2P when a request is pending and T2I when none is pending. T2I drives no strobe.
- R6: T2I moves to T2P as soon as a request is pending before acknowledge. T2P issues the next cycle's address with a one-state strobe and then waits. An acknowledge in T2P leads to T1P.
- R7: Two address strobes are never closer than two clocks apart. The address does not change in a state without a strobe.
- R8: A read acknowledge raises `rd_latch` in the acknowledging state. For a write, `data_oe` is high from the cycle's first state through the acknowledging state, plus exactly one state after it.
- R9: If `half_n` is low when a T2 cycle is acknowledged, and both halves of `be_out` are non-zero, the next state is T1 with the same address and direction and the lower half of the byte enables cleared. This happens before a pending hold and without taking a new request. When `half_n` and next-address are both low, the half-width indication wins and no pipelining starts.
- R10: Hold is granted only at a cycle boundary. `hold_ack` is high for every hold state. The bus leaves hold for T1 or idle once `hold_req` falls.
- R11: `req_take` is high exactly at the edges where the request is loaded onto the bus. Every strobe shows the accepted requests (and split halves) in order, with their address, byte enables and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal request pending |
| req_addr | input | AW | Address of the pending request |
| req_be | input | BEW | Byte enables of the pending request (active high) |
| req_write | input | 1 | Direction of the pending request, 1 = write |
| req_take | output | 1 | Request accepted at this edge |
| rdy_n | input | 1 | Cycle acknowledge, active low |
| nxt_n | input | 1 | Next-address request, active low |
| half_n | input | 1 | Half-width bus indication, active low |
| hold_req | input | 1 | Request for the bus to be released |
| ads_n | output | 1 | Address strobe, active low |
| addr_out | output | AW | Bus address |
| be_out | output | BEW | Bus byte enables (active high) |
| wr_out | output | 1 | Bus cycle direction, 1 = write |
| data_oe | output | 1 | Write data bus drive enable |
| rd_latch | output | 1 | Read data capture strobe |
| hold_ack | output | 1 | Hold granted |
| bus_state | output | 3 | Current bus state code |

## Verification
The hardest situation to reach is a pipelined cycle that passes through T2I and then T2P. To get there, next-address must be sampled low in the first state of a pipelined cycle while no request is pending. A request must then arrive while that cycle is still waiting for ready. The stimulus builds this step by step. It starts a read after idle and gives it a wait state so that next-address can be sampled. It queues a write so that the read ends in T2P. It then withholds further requests during T1P and posts one only after T2I is observed. A separate sequence holds `half_n` and next-address low together and also asserts hold at the split acknowledge. This shows the split cycle taking priority over both pipelining and hold.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bus cycle sequencer.
// Assumes one clock per bus state; state codes are visible at the top port.
package bseq_pkg;

    typedef enum logic [2:0] {
        ST_TI  = 3'd0,   // idle
        ST_TH  = 3'd1,   // bus released to another master
        ST_T1  = 3'd2,   // first state, non-pipelined cycle
        ST_T2  = 3'd3,   // later state, next-address not yet taken
        ST_T2I = 3'd4,   // next-address taken, nothing to issue
        ST_T2P = 3'd5,   // next-address taken, next cycle issued
        ST_T1P = 3'd6    // first state, pipelined cycle
    } bstate_t;

    // States in which ready is sampled.
    function automatic logic ready_window(bstate_t s);
        return (s == ST_T2) || (s == ST_T2I) || (s == ST_T2P);
    endfunction

    // States that open a new cycle.
    function automatic logic opens_cycle(bstate_t s);
        return (s == ST_T1) || (s == ST_T1P);
    endfunction

endpackage

// File: rtl/bseq_fsm.sv
`timescale 1ns/1ps
// Bus state sequencer core.
// Holds the bus state and decides the next one from ready, next-address,
// half-width, hold and the internal request. Reports when the request is
// loaded (issue_new), when a split second half is started (issue_split)
// and when the current cycle is acknowledged (ack).
// Assumes the requester keeps req_valid high until it sees issue_new.
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    rdy_n,
    input  logic    nxt_n,
    input  logic    half_n,
    input  logic    hold_req,
    input  logic    split_need,
    output bstate_t state_q,
    output bstate_t nxt_state,
    output logic    issue_new,
    output logic    issue_split,
    output logic    ack,
    output logic    hold_ack
);

    logic    na_taken;     // next-address accepted this state
    bstate_t bound_state;  // where a plain cycle boundary leads
    logic    bound_issue;  // that boundary loads the request

    // Next-address counts only when half-width is not asserted.
    assign na_taken = !nxt_n && half_n;
    assign ack      = ready_window(state_q) && !rdy_n;
    assign hold_ack = (state_q == ST_TH);

    // Choice at a cycle boundary: hold first, then a request, else idle.
    always_comb begin
        bound_issue = 1'b0;
        if (hold_req) begin
            bound_state = ST_TH;
        end else if (req_valid) begin
            bound_state = ST_T1;
            bound_issue = 1'b1;
        end else begin
            bound_state = ST_TI;
        end
    end

    // Next-state decision for every bus state.
    always_comb begin
        nxt_state   = state_q;
        issue_new   = 1'b0;
        issue_split = 1'b0;
        case (state_q)
            ST_TI, ST_TH: begin
                nxt_state = bound_state;
                issue_new = bound_issue;
            end
            ST_T1: begin
                nxt_state = ST_T2;
            end
            ST_T1P: begin
                if (na_taken) begin
                    nxt_state = req_valid ? ST_T2P : ST_T2I;
                    issue_new = req_valid;
                end else begin
                    nxt_state = ST_T2;
                end
            end
            ST_T2: begin
                if (ack) begin
                    if (!half_n && split_need) begin
                        nxt_state   = ST_T1;
                        issue_split = 1'b1;
                    end else begin
                        nxt_state = bound_state;
                        issue_new = bound_issue;
                    end
                end else if (na_taken) begin
                    nxt_state = req_valid ? ST_T2P : ST_T2I;
                    issue_new = req_valid;
                end
            end
            ST_T2I: begin
                if (ack) begin
                    nxt_state = bound_state;
                    issue_new = bound_issue;
                end else if (req_valid) begin
                    nxt_state = ST_T2P;
                    issue_new = 1'b1;
                end
            end
            ST_T2P: begin
                if (ack) begin
                    nxt_state = ST_T1P;
                end
            end
            default: begin
                nxt_state = ST_TI;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_TI;
        end else begin
            state_q <= nxt_state;
        end
    end

endmodule

// File: rtl/bseq_addr_regs.sv
`timescale 1ns/1ps
// Address and cycle-definition registers with the address strobe.
// Loads the request on issue_new; on issue_split keeps address and
// direction and clears the lower half of the byte enables. The strobe
// is registered and lasts exactly the state after a load.
// Assumes BEW is even.
module bseq_addr_regs #(
    parameter int AW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_new,
    input  logic           issue_split,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic           req_write,
    output logic [AW-1:0]  addr_q,
    output logic [BEW-1:0] be_q,
    output logic           wr_q,
    output logic           ads_n,
    output logic           split_need
);

    localparam int HALF = BEW / 2;

    logic [BEW-1:0] upper_mask;
    logic           ads_q;

    // Build the mask that keeps only the upper half of the lanes.
    for (genvar g = 0; g < BEW; g++) begin : g_mask
        assign upper_mask[g] = (g >= HALF);
    end

    // A split is needed when both halves carry enabled lanes.
    assign split_need = (|(be_q & ~upper_mask)) && (|(be_q & upper_mask));
    assign ads_n      = !ads_q;

    // Cycle definition registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '0;
            wr_q   <= 1'b0;
        end else if (issue_new) begin
            addr_q <= req_addr;
            be_q   <= req_be;
            wr_q   <= req_write;
        end else if (issue_split) begin
            be_q   <= be_q & upper_mask;
        end
    end

    // One-state address strobe following every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ads_q <= 1'b0;
        end else begin
            ads_q <= issue_new || issue_split;
        end
    end

endmodule

// File: rtl/bseq_data_ctl.sv
`timescale 1ns/1ps
// Data bus control.
// Tracks the direction of the cycle in progress. That can differ from the
// definition on the bus once the next cycle has been issued early. Drives
// the write enable from the first state of a write through one state after
// its acknowledge, and the read capture strobe in a read's acknowledge state.
module bseq_data_ctl
    import bseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bstate_t nxt_state,
    input  logic    ack,
    input  logic    issue_new,
    input  logic    req_write,
    input  logic    wr_q,
    output logic    data_oe,
    output logic    rd_latch
);

    logic cur_wr;      // direction of the cycle in progress
    logic start;       // a cycle opens at this edge
    logic stays;       // the same cycle carries on at this edge
    logic new_wr;      // direction of the cycle that opens
    logic oe_d;

    assign start    = opens_cycle(nxt_state);
    assign stays    = ready_window(nxt_state);
    assign new_wr   = issue_new ? req_write : wr_q;
    assign rd_latch = ack && !cur_wr;

    // Drive enable for the coming state: own write, or hold after a write ack.
    always_comb begin
        if (start) begin
            oe_d = new_wr;
        end else if (stays) begin
            oe_d = cur_wr;
        end else begin
            oe_d = 1'b0;
        end
        oe_d = oe_d || (ack && cur_wr);
    end

    // Current direction and drive enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr  <= 1'b0;
            data_oe <= 1'b0;
        end else begin
            if (start) begin
                cur_wr <= new_wr;
            end
            data_oe <= oe_d;
        end
    end

endmodule

// File: rtl/pipe_bus_seq.sv
`timescale 1ns/1ps
// Pipelined-address bus cycle sequencer, top level.
// Connects the state core, the address/definition registers and the data
// bus control. One clock equals one bus state. The requester holds its
// request until req_take is seen high at a clock edge.
module pipe_bus_seq #(
    parameter int AW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic           req_write,
    output logic           req_take,
    input  logic           rdy_n,
    input  logic           nxt_n,
    input  logic           half_n,
    input  logic           hold_req,
    output logic           ads_n,
    output logic [AW-1:0]  addr_out,
    output logic [BEW-1:0] be_out,
    output logic           wr_out,
    output logic           data_oe,
    output logic           rd_latch,
    output logic           hold_ack,
    output logic [2:0]     bus_state
);

    import bseq_pkg::*;

    bstate_t state_q;
    bstate_t nxt_state;
    logic    issue_new;
    logic    issue_split;
    logic    ack;
    logic    split_need;

    assign req_take  = issue_new;
    assign bus_state = state_q;

    // State sequencing.
    bseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .rdy_n       (rdy_n),
        .nxt_n       (nxt_n),
        .half_n      (half_n),
        .hold_req    (hold_req),
        .split_need  (split_need),
        .state_q     (state_q),
        .nxt_state   (nxt_state),
        .issue_new   (issue_new),
        .issue_split (issue_split),
        .ack         (ack),
        .hold_ack    (hold_ack)
    );

    // Address, byte enables, direction and strobe.
    bseq_addr_regs #(
        .AW  (AW),
        .BEW (BEW)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_new   (issue_new),
        .issue_split (issue_split),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_write   (req_write),
        .addr_q      (addr_out),
        .be_q        (be_out),
        .wr_q        (wr_out),
        .ads_n       (ads_n),
        .split_need  (split_need)
    );

    // Data bus drive and read capture.
    bseq_data_ctl u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .ack       (ack),
        .issue_new (issue_new),
        .req_write (req_write),
        .wr_q      (wr_out),
        .data_oe   (data_oe),
        .rd_latch  (rd_latch)
    );

endmodule

// File: rtl/bseq_checker.sv
`timescale 1ns/1ps
// Protocol checker for pipe_bus_seq, attached by bind.
// Watches only top-level ports; every property is disabled during reset.
module bseq_checker
    import bseq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rdy_n,
    input logic          ads_n,
    input logic [AW-1:0] addr_out,
    input logic          data_oe,
    input logic          rd_latch,
    input logic          hold_ack,
    input logic [2:0]    bus_state
);

    // R2: T1 is always followed by T2.
    a_r2_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T1) |=> (bus_state == ST_T2));

    // R2: T1 carries the strobe.
    a_r2_t1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T1) |-> !ads_n);

    // R3: T2P without ready repeats.
    a_r3_t2p_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T2P && rdy_n) |=> (bus_state == ST_T2P));

    // R5: T2I never strobes.
    a_r5_t2i_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T2I) |-> ads_n);

    // R6: acknowledge in T2P opens a pipelined cycle.
    a_r6_t2p_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T2P && !rdy_n) |=> (bus_state == ST_T1P));

    // R7: strobes at least two clocks apart.
    a_r7_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    // R7: address only moves together with a strobe.
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ads_n |-> $stable(addr_out));

    // R8: the bus is not driven while read data is captured.
    a_r8_latch_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch |-> !data_oe);

    // R10: no hold grant out of a cycle still waiting in T2.
    a_r10_no_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T2 && rdy_n) |=> !hold_ack);

endmodule

bind pipe_bus_seq bseq_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdy_n     (rdy_n),
    .ads_n     (ads_n),
    .addr_out  (addr_out),
    .data_oe   (data_oe),
    .rd_latch  (rd_latch),
    .hold_ack  (hold_ack),
    .bus_state (bus_state)
);

// File: tb/pipe_bus_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: post() queues a request and its expected strobe,
// the monitor pops and compares on every strobe.
module pipe_bus_seq_bench;

    localparam int AW  = 32;
    localparam int BEW = 4;
    localparam int S_TI = 0, S_TH = 1, S_T1 = 2, S_T2 = 3, S_T2I = 4, S_T2P = 5, S_T1P = 6;

    typedef struct {
        logic [AW-1:0]  a;
        logic [BEW-1:0] be;
        logic           wr;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [BEW-1:0] req_be = '0;
    logic           req_write = 1'b0;
    logic           req_take;
    logic           rdy_n = 1'b1;
    logic           nxt_n = 1'b1;
    logic           half_n = 1'b1;
    logic           hold_req = 1'b0;
    logic           ads_n;
    logic [AW-1:0]  addr_out;
    logic [BEW-1:0] be_out;
    logic           wr_out;
    logic           data_oe;
    logic           rd_latch;
    logic           hold_ack;
    logic [2:0]     bus_state;

    item_t exp_q[$];
    item_t pend_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    took;
    bit    rl;

    always #2.5 clk = ~clk;

    pipe_bus_seq #(.AW(AW), .BEW(BEW)) u_pipe_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_be(req_be), .req_write(req_write), .req_take(req_take),
        .rdy_n(rdy_n), .nxt_n(nxt_n), .half_n(half_n), .hold_req(hold_req),
        .ads_n(ads_n), .addr_out(addr_out), .be_out(be_out), .wr_out(wr_out),
        .data_oe(data_oe), .rd_latch(rd_latch), .hold_ack(hold_ack),
        .bus_state(bus_state)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic present(item_t it);
        req_valid = 1'b1;
        req_addr  = it.a;
        req_be    = it.be;
        req_write = it.wr;
    endtask

    // Driver: queue a request and its expected strobe.
    task automatic post(logic [AW-1:0] a, logic [BEW-1:0] be, logic wr);
        item_t it;
        it.a = a; it.be = be; it.wr = wr;
        exp_q.push_back(it);
        if (!req_valid) present(it);
        else pend_q.push_back(it);
    endtask

    // One bus state: capture combinational outputs for the coming edge.
    task automatic cyc();
        #1;
        took = req_valid && req_take;
        rl   = rd_latch;
        @(negedge clk);
        if (took) begin
            req_valid = 1'b0;
            if (pend_q.size() > 0) present(pend_q.pop_front());
        end
    endtask

    // Monitor: every strobe must match the next expected item (R11).
    always @(negedge clk) begin
        if (rst_n && ads_n === 1'b0) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 strobe with empty scoreboard actual %0h expected none", addr_out);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk("R11 strobe address", addr_out, e.a);
                chk("R11 strobe byte enables", 32'(be_out), 32'(e.be));
                chk("R11 strobe direction", 32'(wr_out), 32'(e.wr));
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 state after reset", 32'(bus_state), S_TI);
        chk("R1 strobe after reset", 32'(ads_n), 1);
        chk("R1 data enable after reset", 32'(data_oe), 0);
        chk("R1 hold ack after reset", 32'(hold_ack), 0);

        // Two reads back to back, zero wait states.
        post(32'h1000_0040, 4'hF, 1'b0);
        post(32'h1000_0044, 4'h3, 1'b0);
        rdy_n = 1'b0;
        cyc();
        chk("R2 idle to T1", 32'(bus_state), S_T1);
        chk("R2 strobe in T1", 32'(ads_n), 0);
        chk("R11 take on T1 entry", 32'(took), 1);
        cyc();
        chk("R3 ready ignored in T1", 32'(bus_state), S_T2);
        cyc();
        chk("R8 read latch on ack", 32'(rl), 1);
        chk("R4 ack with request pending to T1", 32'(bus_state), S_T1);
        cyc();
        cyc();
        chk("R4 ack with nothing pending to idle", 32'(bus_state), S_TI);
        rdy_n = 1'b1;

        // Write with waits and a hold raised mid-cycle.
        post(32'h2000_0010, 4'hF, 1'b1);
        cyc();
        chk("R8 write enable in T1", 32'(data_oe), 1);
        hold_req = 1'b1;
        cyc();
        cyc();
        chk("R3 wait state repeats T2", 32'(bus_state), S_T2);
        chk("R10 no hold inside a cycle", 32'(hold_ack), 0);
        cyc();
        chk("R3 still waiting", 32'(bus_state), S_T2);
        rdy_n = 1'b0;
        cyc();
        chk("R10 hold at boundary", 32'(bus_state), S_TH);
        chk("R10 hold ack in hold", 32'(hold_ack), 1);
        chk("R8 write enable one state past ack", 32'(data_oe), 1);
        chk("R8 no read latch on write ack", 32'(rl), 0);
        hold_req = 1'b0;
        rdy_n = 1'b1;
        cyc();
        chk("R10 hold release to idle", 32'(bus_state), S_TI);
        chk("R8 write enable dropped", 32'(data_oe), 0);

        // Pipelining: read with wait, write issued early, then T2I.
        post(32'h3000_0000, 4'hF, 1'b0);
        post(32'h3000_0100, 4'h3, 1'b1);
        nxt_n = 1'b0;
        cyc();
        cyc();
        chk("R5 next-address ignored in T1", 32'(bus_state), S_T2);
        cyc();
        chk("R5 next-address with request to T2P", 32'(bus_state), S_T2P);
        chk("R6 strobe in T2P", 32'(ads_n), 0);
        chk("R11 take on T2P entry", 32'(took), 1);
        nxt_n = 1'b1;
        cyc();
        chk("R3 T2P waits", 32'(bus_state), S_T2P);
        chk("R6 strobe lasts one state", 32'(ads_n), 1);
        rdy_n = 1'b0;
        cyc();
        chk("R6 ack in T2P to T1P", 32'(bus_state), S_T1P);
        chk("R8 read latch on pipelined ack", 32'(rl), 1);
        chk("R8 write enable in T1P", 32'(data_oe), 1);
        nxt_n = 1'b0;
        cyc();
        chk("R5 next-address without request to T2I", 32'(bus_state), S_T2I);
        chk("R5 no strobe in T2I", 32'(ads_n), 1);
        nxt_n = 1'b1;
        rdy_n = 1'b1;
        post(32'h3000_0200, 4'hF, 1'b0);
        cyc();
        chk("R6 T2I to T2P on request", 32'(bus_state), S_T2P);
        rdy_n = 1'b0;
        cyc();
        chk("R6 second pipelined cycle", 32'(bus_state), S_T1P);
        chk("R8 write enable after pipelined write ack", 32'(data_oe), 1);
        cyc();
        chk("R5 no next-address leaves T1P to T2", 32'(bus_state), S_T2);
        chk("R8 read cycle not driving", 32'(data_oe), 0);
        cyc();
        chk("R8 read latch", 32'(rl), 1);
        chk("R4 idle after read", 32'(bus_state), S_TI);
        rdy_n = 1'b1;

        // T2I acknowledged straight to idle.
        post(32'h3800_0000, 4'h1, 1'b0);
        cyc();
        nxt_n = 1'b0;
        cyc();
        cyc();
        chk("R5 T2 to T2I", 32'(bus_state), S_T2I);
        nxt_n = 1'b1;
        rdy_n = 1'b0;
        cyc();
        chk("R4 T2I ack to idle", 32'(bus_state), S_TI);
        rdy_n = 1'b1;

        // Split cycle beats both pipelining and hold.
        post(32'h4000_0020, 4'hF, 1'b1);
        begin
            item_t s;
            s.a = 32'h4000_0020; s.be = 4'hC; s.wr = 1'b1;
            exp_q.push_back(s);
        end
        post(32'h4000_0080, 4'hF, 1'b0);
        cyc();
        cyc();
        nxt_n = 1'b0;
        half_n = 1'b0;
        cyc();
        chk("R9 half-width beats next-address", 32'(bus_state), S_T2);
        nxt_n = 1'b1;
        rdy_n = 1'b0;
        hold_req = 1'b1;
        cyc();
        chk("R9 split second half in T1", 32'(bus_state), S_T1);
        chk("R9 split takes no request", 32'(took), 0);
        chk("R9 request still pending", 32'(req_valid), 1);
        rdy_n = 1'b1;
        half_n = 1'b1;
        cyc();
        rdy_n = 1'b0;
        half_n = 1'b0;
        cyc();
        chk("R10 hold after split completes", 32'(bus_state), S_TH);
        half_n = 1'b1;
        rdy_n = 1'b1;
        cyc();
        chk("R10 stays in hold with request", 32'(bus_state), S_TH);
        chk("R10 hold ack held", 32'(hold_ack), 1);
        hold_req = 1'b0;
        cyc();
        chk("R10 hold release to T1", 32'(bus_state), S_T1);
        chk("R10 hold ack dropped", 32'(hold_ack), 0);
        cyc();
        rdy_n = 1'b0;
        cyc();
        chk("R8 read latch after hold", 32'(rl), 1);
        rdy_n = 1'b1;
        cyc();
        cyc();
        chk("R11 scoreboard drained", 32'(exp_q.size()), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule